// File: doc/BRIEF.md
# Display Fetch Address Generator

This block produces the frame-buffer read addresses, counted in DWORDs, that the scan-out path of a raster display controller needs. It is driven by two timing strobes: a frame strobe that rewinds the block to the top of the picture, and a line strobe that marks the start of each output line. For every line that needs data, it issues a burst of read addresses through a valid/ready handshake. The burst starts at the line's base address, and the base moves forward by a programmed line delta from one source line to the next.

Three compatibility features can be switched on independently, and each is off when its enable input is low. Split-screen restart sends the address back to zero at a programmed line. Line doubling shows every odd output line as a repeat of the even line before it. The display timing is set up as for an undoubled mode, and only half the source lines are read. During a repeated line the block raises a replay flag and issues no fetches. Skip mode makes the block fetch every fourth DWORD instead of every DWORD.

Top module: `disp_fetch_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `fetch_valid` is 0, `line_replay` is 0 and `fetch_addr` is 0.
- R2: `frame_start` sets the output-line index to 0, loads the base with `cfg_start_offset`, drops `fetch_valid` and `line_replay` in the next cycle, and causes a `line_start` in the same cycle to be ignored. The first line after a frame start fetches from `cfg_start_offset`.
- R3: In the cycle after a fetched `line_start`, `fetch_valid` is 1 and `fetch_addr` equals the line base. Exactly `cfg_line_dwords` requests are accepted, after which `fetch_valid` returns to 0. With `cfg_line_dwords` = 0 no request is made.
- R4: While `fetch_valid` is 1 and `fetch_ready` is 0, `fetch_addr` and `fetch_valid` hold.
- R5: Each non-replayed line after line 0 takes as its base the previous base plus `cfg_line_delta`, unless R6 applies.
- R6: When `cfg_split_en` is 1 and the output-line index (0 is the first line after a frame start) equals `cfg_split_line`, that line fetches from base 0. Later lines advance from 0. A split match takes priority over replay.
- R7: When `cfg_dbl_en` is 1, every odd-indexed output line is a replay. `line_replay` is 1 from the cycle after its `line_start` until the next strobe, no fetch is issued, and the base holds.
- R8: Within a line, each accepted request advances `fetch_addr` by 4 if `cfg_skip4_en` was 1 at the line's `line_start`, and by 1 otherwise.
- R9: A `line_start` that arrives while a burst is still in progress abandons the rest of that burst. The next cycle shows the new line's base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe marking the start of a frame |
| line_start | input | 1 | One-cycle strobe marking the start of an output line |
| cfg_start_offset | input | AW | DWORD address of the first source line |
| cfg_line_delta | input | AW | DWORD distance between consecutive source lines |
| cfg_line_dwords | input | CW | Number of fetch requests per fetched line |
| cfg_split_en | input | 1 | Enable for split-screen restart |
| cfg_split_line | input | LW | Output-line index at which the address restarts at 0 |
| cfg_dbl_en | input | 1 | Enable for line doubling |
| cfg_skip4_en | input | 1 | Enable for fetching every fourth DWORD |
| fetch_ready | input | 1 | The consumer accepts the current request |
| fetch_valid | output | 1 | A fetch request is present |
| fetch_addr | output | AW | DWORD address of the current request |
| line_replay | output | 1 | The current line repeats the previous line's data |

## Verification
The bound checker checks several properties on every cycle. It checks that a frame strobe clears the outputs, that a stalled request holds, and that accepted requests step by the stride latched at the line start. It also checks that a split match lands on address 0 and that a doubled odd line raises the replay flag with no fetch. The checker keeps its own count of output lines for these checks. The base arithmetic across several lines can only be shown by the bench's frame scenarios, which compare against a model of the requirements. These scenarios cover the delta accumulation, the base hold through replayed lines, the resumption after a split, the abandonment of a burst and a frame strobe that collides with a line strobe.

// File: rtl/dfa_pkg.sv
// Package: shared types for the display fetch address generator.
// Assumes nothing beyond standard SystemVerilog.
package dfa_pkg;

    // Treatment of an output line, decided at its line strobe.
    typedef enum logic [1:0] {
        LK_FETCH   = 2'd0,  // fetch from an advanced (or initial) base
        LK_REPLAY  = 2'd1,  // doubled odd line: reuse buffered data
        LK_RESTART = 2'd2   // split-screen match: fetch from address 0
    } line_kind_e;

endpackage

// File: rtl/dfa_line_tracker.sv
// Module: dfa_line_tracker
// Counts output lines within a frame and keeps the source-line base
// address. At each line strobe it decides whether the line is fetched,
// replayed or restarted at zero. Assumes frame_start wins over line_start.
module dfa_line_tracker
    import dfa_pkg::*;
#(
    parameter int AW = 24,
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          line_start,
    input  logic [AW-1:0] start_offset,
    input  logic [AW-1:0] line_delta,
    input  logic          split_en,
    input  logic [LW-1:0] split_line,
    input  logic          dbl_en,
    output logic [AW-1:0] base_nxt,
    output logic          line_fetch,
    output logic          replay
);

    logic [LW-1:0] line_cnt_q;
    logic [AW-1:0] base_q;
    logic          replay_q;
    line_kind_e    kind;

    // Classify the line about to start; the split match has priority.
    always_comb begin
        if (split_en && (line_cnt_q == split_line)) begin
            kind = LK_RESTART;
        end else if (dbl_en && line_cnt_q[0]) begin
            kind = LK_REPLAY;
        end else begin
            kind = LK_FETCH;
        end
    end

    // Work out the base address of the line about to start.
    always_comb begin
        unique case (kind)
            LK_RESTART: base_nxt = '0;
            LK_REPLAY:  base_nxt = base_q;
            default:    base_nxt = (line_cnt_q == '0) ? base_q : base_q + line_delta;
        endcase
    end

    // A line is fetched unless it is a replay or a frame strobe overrides it.
    assign line_fetch = line_start && !frame_start && (kind != LK_REPLAY);
    assign replay     = replay_q;

    // Keep the line index, the base and the replay flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt_q <= '0;
            base_q     <= '0;
            replay_q   <= 1'b0;
        end else if (frame_start) begin
            line_cnt_q <= '0;
            base_q     <= start_offset;
            replay_q   <= 1'b0;
        end else if (line_start) begin
            line_cnt_q <= line_cnt_q + 1'b1;
            base_q     <= base_nxt;
            replay_q   <= (kind == LK_REPLAY);
        end
    end

endmodule

// File: rtl/dfa_word_seq.sv
// Module: dfa_word_seq
// Issues the DWORD requests of one line through a valid/ready handshake,
// stepping by 1 or by 4. The stride is latched at the line strobe.
// Assumes fetch_ready may be asserted at any time.
module dfa_word_seq #(
    parameter int AW = 24,
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          line_start,
    input  logic          line_fetch,
    input  logic [AW-1:0] base_nxt,
    input  logic [CW-1:0] line_dwords,
    input  logic          skip4_en,
    input  logic          fetch_ready,
    output logic          fetch_valid,
    output logic [AW-1:0] fetch_addr
);

    localparam logic [AW-1:0] STEP_ONE  = AW'(1);
    localparam logic [AW-1:0] STEP_FOUR = AW'(4);

    logic          valid_q;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] remain_q;
    logic          skip4_q;
    logic [AW-1:0] step;

    // Choose the address step for the current line.
    assign step = skip4_q ? STEP_FOUR : STEP_ONE;

    // Start, advance, finish or abandon the burst of the current line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            addr_q   <= '0;
            remain_q <= '0;
            skip4_q  <= 1'b0;
        end else if (frame_start) begin
            valid_q  <= 1'b0;
        end else if (line_start) begin
            if (line_fetch && (line_dwords != '0)) begin
                valid_q  <= 1'b1;
                addr_q   <= base_nxt;
                remain_q <= line_dwords - 1'b1;
                skip4_q  <= skip4_en;
            end else begin
                valid_q  <= 1'b0;
            end
        end else if (valid_q && fetch_ready) begin
            if (remain_q == '0) begin
                valid_q  <= 1'b0;
            end else begin
                addr_q   <= addr_q + step;
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    assign fetch_valid = valid_q;
    assign fetch_addr  = addr_q;

endmodule

// File: rtl/disp_fetch_addr_gen.sv
// Module: disp_fetch_addr_gen (top)
// Generates the frame-buffer fetch addresses for display scan-out. It
// supports split-screen restart, line doubling with a replay flag, and
// fetching every fourth DWORD. Assumes the strobes last one cycle each.
module disp_fetch_addr_gen #(
    parameter int AW = 24,
    parameter int LW = 11,
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          line_start,
    input  logic [AW-1:0] cfg_start_offset,
    input  logic [AW-1:0] cfg_line_delta,
    input  logic [CW-1:0] cfg_line_dwords,
    input  logic          cfg_split_en,
    input  logic [LW-1:0] cfg_split_line,
    input  logic          cfg_dbl_en,
    input  logic          cfg_skip4_en,
    input  logic          fetch_ready,
    output logic          fetch_valid,
    output logic [AW-1:0] fetch_addr,
    output logic          line_replay
);

    logic [AW-1:0] base_nxt;
    logic          line_fetch;

    // Line index, line base and replay decision.
    dfa_line_tracker #(.AW(AW), .LW(LW)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .line_start   (line_start),
        .start_offset (cfg_start_offset),
        .line_delta   (cfg_line_delta),
        .split_en     (cfg_split_en),
        .split_line   (cfg_split_line),
        .dbl_en       (cfg_dbl_en),
        .base_nxt     (base_nxt),
        .line_fetch   (line_fetch),
        .replay       (line_replay)
    );

    // Request burst within a line.
    dfa_word_seq #(.AW(AW), .CW(CW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .line_start   (line_start),
        .line_fetch   (line_fetch),
        .base_nxt     (base_nxt),
        .line_dwords  (cfg_line_dwords),
        .skip4_en     (cfg_skip4_en),
        .fetch_ready  (fetch_ready),
        .fetch_valid  (fetch_valid),
        .fetch_addr   (fetch_addr)
    );

endmodule

// File: rtl/dfa_checker.sv
// Module: dfa_checker
// Checks properties of the generator at its ports. It keeps its own
// line count and its own latched stride. It is attached by bind below.
module dfa_checker #(
    parameter int AW = 24,
    parameter int LW = 11,
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_start,
    input logic          line_start,
    input logic [CW-1:0] cfg_line_dwords,
    input logic          cfg_split_en,
    input logic [LW-1:0] cfg_split_line,
    input logic          cfg_dbl_en,
    input logic          cfg_skip4_en,
    input logic          fetch_ready,
    input logic          fetch_valid,
    input logic [AW-1:0] fetch_addr,
    input logic          line_replay
);

    logic [LW-1:0] chk_line;
    logic          chk_skip4;

    // Independent count of output lines and of the stride chosen per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_line  <= '0;
            chk_skip4 <= 1'b0;
        end else if (frame_start) begin
            chk_line  <= '0;
        end else if (line_start) begin
            chk_line  <= chk_line + 1'b1;
            chk_skip4 <= cfg_skip4_en;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !fetch_valid && !line_replay && (fetch_addr == '0)); // R1

    AST_FRAME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !fetch_valid && !line_replay); // R2

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && !fetch_ready && !line_start && !frame_start
        |=> fetch_valid && $stable(fetch_addr)); // R4

    AST_STRIDE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && fetch_ready && !line_start && !frame_start
        |=> !fetch_valid ||
            (fetch_addr == $past(fetch_addr) + (chk_skip4 ? AW'(4) : AW'(1)))); // R8

    AST_SPLIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        line_start && !frame_start && cfg_split_en && (chk_line == cfg_split_line)
        && (cfg_line_dwords != '0)
        |=> fetch_valid && (fetch_addr == '0) && !line_replay); // R6

    AST_DOUBLE_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        line_start && !frame_start && cfg_dbl_en && chk_line[0]
        && !(cfg_split_en && (chk_line == cfg_split_line))
        |=> line_replay && !fetch_valid); // R7

    AST_REPLAY_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        line_replay |-> !fetch_valid); // R7

endmodule

bind disp_fetch_addr_gen dfa_checker #(.AW(AW), .LW(LW), .CW(CW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .frame_start     (frame_start),
    .line_start      (line_start),
    .cfg_line_dwords (cfg_line_dwords),
    .cfg_split_en    (cfg_split_en),
    .cfg_split_line  (cfg_split_line),
    .cfg_dbl_en      (cfg_dbl_en),
    .cfg_skip4_en    (cfg_skip4_en),
    .fetch_ready     (fetch_ready),
    .fetch_valid     (fetch_valid),
    .fetch_addr      (fetch_addr),
    .line_replay     (line_replay)
);

// File: tb/disp_fetch_addr_gen_tb.sv
module disp_fetch_addr_gen_tb;

    localparam int AW = 24;
    localparam int LW = 11;
    localparam int CW = 10;
    localparam logic [AW-1:0] OFFS  = 24'h000100;
    localparam logic [AW-1:0] DELTA = 24'h000050;
    localparam int NWORDS = 4;

    // Vector: {dbl, split_en, split_line[3:0], skip4, observed line[3:0]}
    localparam int NV = 9;
    localparam logic [10:0] VEC [NV] = '{
        {1'b0, 1'b0, 4'd0, 1'b0, 4'd0},
        {1'b0, 1'b0, 4'd0, 1'b0, 4'd3},
        {1'b0, 1'b0, 4'd0, 1'b1, 4'd2},
        {1'b1, 1'b0, 4'd0, 1'b0, 4'd1},
        {1'b1, 1'b0, 4'd0, 1'b0, 4'd4},
        {1'b0, 1'b1, 4'd2, 1'b0, 4'd2},
        {1'b0, 1'b1, 4'd2, 1'b0, 4'd4},
        {1'b1, 1'b1, 4'd3, 1'b0, 4'd3},
        {1'b1, 1'b1, 4'd3, 1'b1, 4'd4}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          line_start = 1'b0;
    logic [AW-1:0] cfg_start_offset = OFFS;
    logic [AW-1:0] cfg_line_delta = DELTA;
    logic [CW-1:0] cfg_line_dwords = CW'(NWORDS);
    logic          cfg_split_en = 1'b0;
    logic [LW-1:0] cfg_split_line = '0;
    logic          cfg_dbl_en = 1'b0;
    logic          cfg_skip4_en = 1'b0;
    logic          fetch_ready = 1'b1;
    logic          fetch_valid;
    logic [AW-1:0] fetch_addr;
    logic          line_replay;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    disp_fetch_addr_gen #(.AW(AW), .LW(LW), .CW(CW)) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .frame_start      (frame_start),
        .line_start       (line_start),
        .cfg_start_offset (cfg_start_offset),
        .cfg_line_delta   (cfg_line_delta),
        .cfg_line_dwords  (cfg_line_dwords),
        .cfg_split_en     (cfg_split_en),
        .cfg_split_line   (cfg_split_line),
        .cfg_dbl_en       (cfg_dbl_en),
        .cfg_skip4_en     (cfg_skip4_en),
        .fetch_ready      (fetch_ready),
        .fetch_valid      (fetch_valid),
        .fetch_addr       (fetch_addr),
        .line_replay      (line_replay)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive the strobes for one cycle; return at the negedge after the sampling edge.
    task automatic pulse(input logic fs, input logic ls);
        @(negedge clk);
        frame_start = fs;
        line_start  = ls;
        @(negedge clk);
        frame_start = 1'b0;
        line_start  = 1'b0;
    endtask

    // Start a line and collect its burst with ready held high.
    task automatic run_line(output int cnt, output logic [AW-1:0] first,
                            output logic [AW-1:0] last, output logic rep);
        pulse(1'b0, 1'b1);
        cnt = 0; first = '0; last = '0;
        rep = line_replay;
        for (int k = 0; k < 12; k++) begin
            if (fetch_valid) begin
                if (cnt == 0) first = fetch_addr;
                last = fetch_addr;
                cnt++;
            end
            @(negedge clk);
        end
    endtask

    // Model of the line base and replay decision, written from R2, R5, R6 and R7.
    function automatic logic [AW:0] model(input logic dbl, input logic sen,
                                          input int sline, input int obs);
        logic [AW-1:0] b;
        logic r;
        b = OFFS; r = 1'b0;
        for (int n = 0; n <= obs; n++) begin
            if (sen && n == sline) begin b = '0; r = 1'b0; end
            else if (dbl && n[0]) r = 1'b1;
            else begin r = 1'b0; if (n != 0) b = b + DELTA; end
        end
        return {r, b};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int cnt;
        logic [AW-1:0] first, last, base;
        logic rep;
        logic [AW:0] m;
        int step;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", 32'(fetch_valid), 0);
        check("R1 replay", 32'(line_replay), 0);
        check("R1 addr", 32'(fetch_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: one frame per vector, observe one line.
        for (int v = 0; v < NV; v++) begin
            cfg_dbl_en     = VEC[v][10];
            cfg_split_en   = VEC[v][9];
            cfg_split_line = LW'(VEC[v][8:5]);
            cfg_skip4_en   = VEC[v][4];
            pulse(1'b1, 1'b0);
            // R2: frame strobe clears the outputs
            check("R2 frame clears valid", 32'(fetch_valid), 0);
            for (int n = 0; n <= int'(VEC[v][3:0]); n++) run_line(cnt, first, last, rep);
            m = model(VEC[v][10], VEC[v][9], int'(VEC[v][8:5]), int'(VEC[v][3:0]));
            step = VEC[v][4] ? 4 : 1;
            // R5/R6/R7: base and replay; R3: count; R8: stride
            check("R7 replay flag", 32'(rep), 32'(m[AW]));
            check("R3 word count", 32'(cnt), m[AW] ? 0 : NWORDS);
            if (!m[AW]) begin
                check("R5/R6 line base", 32'(first), 32'(m[AW-1:0]));
                check("R8 last address", 32'(last), 32'(m[AW-1:0] + AW'(step * (NWORDS - 1))));
            end
        end

        cfg_dbl_en = 1'b0; cfg_split_en = 1'b0; cfg_skip4_en = 1'b0;

        // R4: stall holds address and valid
        pulse(1'b1, 1'b0);
        fetch_ready = 1'b0;
        pulse(1'b0, 1'b1);
        for (int k = 0; k < 3; k++) begin
            check("R4 stall valid", 32'(fetch_valid), 1);
            check("R4 stall addr", 32'(fetch_addr), 32'(OFFS));
            @(negedge clk);
        end
        fetch_ready = 1'b1;
        @(negedge clk);
        check("R4 resume addr", 32'(fetch_addr), 32'(OFFS + 1));
        repeat (6) @(negedge clk);
        check("R3 burst ends", 32'(fetch_valid), 0);

        // R9: abandon a burst with a new line strobe
        cfg_line_dwords = CW'(8);
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        @(negedge clk);
        check("R9 mid burst", 32'(fetch_addr), 32'(OFFS + 1));
        pulse(1'b0, 1'b1);
        check("R9 new base", 32'(fetch_addr), 32'(OFFS + DELTA));
        repeat (12) @(negedge clk);
        cfg_line_dwords = CW'(NWORDS);

        // R3: zero words per line gives no request
        cfg_line_dwords = '0;
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        check("R3 zero words", 32'(fetch_valid), 0);
        cfg_line_dwords = CW'(NWORDS);

        // R2: frame strobe wins over a line strobe in the same cycle
        pulse(1'b1, 1'b0);
        run_line(cnt, first, last, rep);
        pulse(1'b1, 1'b1);
        check("R2 collide valid", 32'(fetch_valid), 0);
        run_line(cnt, first, last, rep);
        check("R2 first line base", 32'(first), 32'(OFFS));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule